// File: doc/BRIEF.md
# Board Switch Override and Reset Controller

This block sits behind a byte-wide register bus on a board controller. It watches eight banks of eight physical configuration switches. Software can override any single switch bit: every bank has a shadow byte that holds the value software wants, and a mask byte that picks, bit by bit, whether the shadow bit or the physical switch bit drives the effective configuration. The effective configuration is an output at all times.

The block also issues board resets. Two triggers start a reset pulse of fixed length. At the first cycle of the pulse the block captures a configuration word for the rest of the board to sample. One trigger captures the raw physical switches and ignores every override mask. The other trigger captures the merged, override-aware configuration. The block also holds a 24-bit clock frequency word, split over three byte registers, and an enable bit that tells downstream logic to apply it.

Top module: `swcfg_ctrl`

## Requirements
- R1: After a synchronous reset every shadow and mask byte reads 0x00, `cfg_live` equals `phys_sw`, `board_rst` and `cfg_strobe` are 0, `freq_word` is 0 and `freq_apply` is 0.
- R2: For bank b and bit i, `cfg_live[8*b+i]` equals the shadow bit when the mask bit is 1, and `phys_sw[8*b+i]` when the mask bit is 0.
- R3: The shadow byte of bank b is at address 0x10+2*b and its mask byte is at 0x11+2*b. Both are fully writable and read back the last value written.
- R4: Address 0x00 reads the identity constant (default 0xA7) and 0x01 reads the architecture constant (default 0x12). Writes to them are ignored.
- R5: Addresses that are not mapped read 0x00, and writes to them change no register and no output.
- R6: Any write to address 0x02 starts a reset pulse that captures `phys_sw` unmodified into `cfg_latched`. Address 0x02 reads 0x00.
- R7: Address 0x03 holds a sequencer bit in data bit 0 and reads back as {7'b0, bit}. A write that takes this bit from 0 to 1 starts a reset pulse that captures the merged configuration of R2 into `cfg_latched`.
- R8: A write to 0x03 that leaves the bit at 1, or that clears it, starts no reset.
- R9: `board_rst` goes high in the cycle after the triggering write and stays high for exactly PULSE_LEN cycles (default 16). `cfg_strobe` is high only in the first of those cycles, and `cfg_latched` changes only together with `cfg_strobe`.
- R10: A trigger that arrives while a pulse is active is ignored. The pulse length is unchanged and `cfg_latched` keeps its value.
- R11: Addresses 0x05, 0x06 and 0x07 hold the frequency word, most significant byte at 0x05 and least significant at 0x07. They read back, and `freq_word` presents them concatenated.
- R12: Address 0x04 holds the clock enable in data bit 0 only and reads as {7'b0, bit}. `freq_apply` follows that bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wen | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| phys_sw | input | 64 | Physical switch bits, bank b in bits 8b+7..8b |
| cfg_live | output | 64 | Effective configuration after overrides |
| cfg_latched | output | 64 | Configuration captured at the start of the last reset pulse |
| cfg_strobe | output | 1 | One-cycle strobe that marks the capture |
| board_rst | output | 1 | Board reset pulse, active high |
| freq_word | output | 24 | Stored clock frequency word |
| freq_apply | output | 1 | Clock enable bit |

## Verification
The bench walks mask patterns that are all-clear, all-set, split by nibble and sparse. A mux with the select polarity swapped, or with bits wired from the wrong bank, then shows up on `cfg_live`. Both resets are fired on the same register state with shadow and physical values that differ. A design that mixed up the two capture sources would latch the wrong word. The bench writes 1 twice in a row to the sequencer bit and then writes 0. A level-triggered design would pulse on those writes where an edge-triggered one stays quiet. It also issues a second trigger in the middle of a pulse. A block that restarts its counter would stretch the pulse, and one that recaptures would overwrite the latched word.

// File: rtl/swcfg_pkg.sv
// Shared constants and types for the switch override and reset controller.
// Assumes an 8-bit address space with byte-wide registers.
package swcfg_pkg;

    localparam int BYTE_W     = 8;
    localparam int FREQ_BYTES = 3;

    typedef logic [BYTE_W-1:0] byte_t;

    // Fixed register addresses; bank registers are interleaved from BANK_BASE.
    localparam byte_t A_ID        = 8'h00;
    localparam byte_t A_ARCH      = 8'h01;
    localparam byte_t A_PLAIN_RST = 8'h02;
    localparam byte_t A_SEQ       = 8'h03;
    localparam byte_t A_CLKEN     = 8'h04;
    localparam byte_t A_FREQ0     = 8'h05;
    localparam byte_t A_BANK_BASE = 8'h10;

    // Which configuration a reset pulse captures.
    typedef enum logic {
        SRC_PHYS   = 1'b0,
        SRC_MERGED = 1'b1
    } cfg_src_e;

endpackage

// File: rtl/swcfg_regs.sv
// Register file: shadow and mask bytes per bank, sequencer bit, clock enable,
// frequency bytes and read-only identity bytes. Decodes the two reset triggers.
// Assumes single-cycle writes and a combinational read path.
module swcfg_regs
    import swcfg_pkg::*;
#(
    parameter int    NBANK      = 8,
    parameter byte_t ID_VALUE   = 8'hA7,
    parameter byte_t ARCH_VALUE = 8'h12,
    localparam int   CFG_W      = NBANK * BYTE_W,
    localparam int   FREQ_W     = FREQ_BYTES * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wen,
    input  byte_t             addr,
    input  byte_t             wdata,
    output byte_t             rdata,
    output logic [CFG_W-1:0]  sw_flat,
    output logic [CFG_W-1:0]  en_flat,
    output logic [FREQ_W-1:0] freq_word,
    output logic              freq_apply,
    output logic              plain_trig,
    output logic              seq_trig
);

    byte_t sw_q   [NBANK];
    byte_t en_q   [NBANK];
    byte_t freq_q [FREQ_BYTES];
    logic  seq_q;
    logic  clken_q;

    // Per-bank shadow and mask storage with their own address decode.
    for (genvar g = 0; g < NBANK; g++) begin : g_bank
        localparam byte_t SW_ADDR = A_BANK_BASE + byte_t'(2 * g);
        localparam byte_t EN_ADDR = A_BANK_BASE + byte_t'(2 * g + 1);

        // Shadow byte register.
        always_ff @(posedge clk) begin
            if (!rst_n)                        sw_q[g] <= '0;
            else if (wen && addr == SW_ADDR)   sw_q[g] <= wdata;
        end

        // Mask byte register.
        always_ff @(posedge clk) begin
            if (!rst_n)                        en_q[g] <= '0;
            else if (wen && addr == EN_ADDR)   en_q[g] <= wdata;
        end

        assign sw_flat[g*BYTE_W +: BYTE_W] = sw_q[g];
        assign en_flat[g*BYTE_W +: BYTE_W] = en_q[g];
    end

    // Frequency word bytes; the lowest address is the most significant byte.
    for (genvar f = 0; f < FREQ_BYTES; f++) begin : g_freq
        localparam byte_t F_ADDR = A_FREQ0 + byte_t'(f);

        // Frequency byte register.
        always_ff @(posedge clk) begin
            if (!rst_n)                       freq_q[f] <= '0;
            else if (wen && addr == F_ADDR)   freq_q[f] <= wdata;
        end

        assign freq_word[FREQ_W-1-f*BYTE_W -: BYTE_W] = freq_q[f];
    end

    // Sequencer control bit and clock enable bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q   <= 1'b0;
            clken_q <= 1'b0;
        end else if (wen) begin
            if (addr == A_SEQ)   seq_q   <= wdata[0];
            if (addr == A_CLKEN) clken_q <= wdata[0];
        end
    end

    assign freq_apply = clken_q;

    // Trigger decode: any write to the plain reset address, or a 0->1 on seq.
    always_comb begin
        plain_trig = wen && (addr == A_PLAIN_RST);
        seq_trig   = wen && (addr == A_SEQ) && wdata[0] && !seq_q;
    end

    // Read mux; unmapped addresses return zero.
    always_comb begin
        rdata = '0;
        case (addr)
            A_ID:    rdata = ID_VALUE;
            A_ARCH:  rdata = ARCH_VALUE;
            A_SEQ:   rdata = {{(BYTE_W-1){1'b0}}, seq_q};
            A_CLKEN: rdata = {{(BYTE_W-1){1'b0}}, clken_q};
            default: rdata = '0;
        endcase
        for (int f = 0; f < FREQ_BYTES; f++) begin
            if (addr == A_FREQ0 + byte_t'(f)) rdata = freq_q[f];
        end
        for (int b = 0; b < NBANK; b++) begin
            if (addr == A_BANK_BASE + byte_t'(2 * b))     rdata = sw_q[b];
            if (addr == A_BANK_BASE + byte_t'(2 * b + 1)) rdata = en_q[b];
        end
    end

endmodule

// File: rtl/swcfg_merge.sv
// Per-bit override mux: each effective bit takes the shadow bit when its mask
// bit is set, else the physical switch bit. Purely combinational.
module swcfg_merge #(
    parameter int CFG_W = 64
) (
    input  logic [CFG_W-1:0] phys,
    input  logic [CFG_W-1:0] shadow,
    input  logic [CFG_W-1:0] mask,
    output logic [CFG_W-1:0] merged
);

    // One select per configuration bit.
    for (genvar i = 0; i < CFG_W; i++) begin : g_bit
        assign merged[i] = mask[i] ? shadow[i] : phys[i];
    end

endmodule

// File: rtl/swcfg_rstgen.sv
// Reset pulse generator: a trigger while idle starts a pulse of PULSE_LEN
// cycles, raises a one-cycle strobe and captures the chosen configuration.
// Triggers during an active pulse are dropped. Assumes at most one trigger
// per cycle.
module swcfg_rstgen
    import swcfg_pkg::*;
#(
    parameter int  CFG_W     = 64,
    parameter int  PULSE_LEN = 16,
    localparam int CNT_W     = $clog2(PULSE_LEN + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             plain_trig,
    input  logic             seq_trig,
    input  logic [CFG_W-1:0] phys,
    input  logic [CFG_W-1:0] merged,
    output logic             pulse,
    output logic             strobe,
    output logic [CFG_W-1:0] latched
);

    logic [CNT_W-1:0] cnt_q;
    cfg_src_e         src;
    logic             start;

    // Pick the capture source and qualify the start with the idle state.
    always_comb begin
        src   = seq_trig ? SRC_MERGED : SRC_PHYS;
        start = (plain_trig || seq_trig) && !pulse;
    end

    // Pulse state and down-counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pulse <= 1'b0;
            cnt_q <= '0;
        end else if (start) begin
            pulse <= 1'b1;
            cnt_q <= CNT_W'(PULSE_LEN - 1);
        end else if (pulse) begin
            if (cnt_q == '0) pulse <= 1'b0;
            else             cnt_q <= cnt_q - 1'b1;
        end
    end

    // Capture strobe and latched configuration at the start of a pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            strobe  <= 1'b0;
            latched <= '0;
        end else begin
            strobe <= start;
            if (start) latched <= (src == SRC_MERGED) ? merged : phys;
        end
    end

endmodule

// File: rtl/swcfg_ctrl.sv
// Top level: switch override register block with two board reset triggers
// and a clock frequency word. Byte bus writes are single-cycle; reads are
// combinational on bus_addr.
module swcfg_ctrl
    import swcfg_pkg::*;
#(
    parameter int    NBANK      = 8,
    parameter int    PULSE_LEN  = 16,
    parameter byte_t ID_VALUE   = 8'hA7,
    parameter byte_t ARCH_VALUE = 8'h12,
    localparam int   CFG_W      = NBANK * BYTE_W,
    localparam int   FREQ_W     = FREQ_BYTES * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wen,
    input  logic [7:0]        bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic [CFG_W-1:0]  phys_sw,
    output logic [CFG_W-1:0]  cfg_live,
    output logic [CFG_W-1:0]  cfg_latched,
    output logic              cfg_strobe,
    output logic              board_rst,
    output logic [FREQ_W-1:0] freq_word,
    output logic              freq_apply
);

    logic [CFG_W-1:0] sw_flat;
    logic [CFG_W-1:0] en_flat;
    logic             plain_trig;
    logic             seq_trig;

    swcfg_regs #(
        .NBANK      (NBANK),
        .ID_VALUE   (ID_VALUE),
        .ARCH_VALUE (ARCH_VALUE)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wen        (bus_wen),
        .addr       (bus_addr),
        .wdata      (bus_wdata),
        .rdata      (bus_rdata),
        .sw_flat    (sw_flat),
        .en_flat    (en_flat),
        .freq_word  (freq_word),
        .freq_apply (freq_apply),
        .plain_trig (plain_trig),
        .seq_trig   (seq_trig)
    );

    swcfg_merge #(
        .CFG_W (CFG_W)
    ) u_merge (
        .phys   (phys_sw),
        .shadow (sw_flat),
        .mask   (en_flat),
        .merged (cfg_live)
    );

    swcfg_rstgen #(
        .CFG_W     (CFG_W),
        .PULSE_LEN (PULSE_LEN)
    ) u_rstgen (
        .clk        (clk),
        .rst_n      (rst_n),
        .plain_trig (plain_trig),
        .seq_trig   (seq_trig),
        .phys       (phys_sw),
        .merged     (cfg_live),
        .pulse      (board_rst),
        .strobe     (cfg_strobe),
        .latched    (cfg_latched)
    );

endmodule

// File: rtl/swcfg_ctrl_chk.sv
// Property checker for swcfg_ctrl, attached by bind. Watches the pulse
// shape, the capture strobe, passthrough with no overrides and the clock
// enable stability. Assumes rst_n is driven low from time zero.
module swcfg_ctrl_chk #(
    parameter int  CFG_W     = 64,
    parameter int  PULSE_LEN = 16,
    localparam int RUN_W     = $clog2(PULSE_LEN + 2) + 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_wen,
    input logic [7:0]       bus_addr,
    input logic [CFG_W-1:0] phys_sw,
    input logic [CFG_W-1:0] cfg_live,
    input logic [CFG_W-1:0] cfg_latched,
    input logic             cfg_strobe,
    input logic             board_rst,
    input logic             freq_apply,
    input logic [CFG_W-1:0] en_flat
);

    logic [RUN_W-1:0] run_q;

    // Length of the current high run of board_rst.
    always_ff @(posedge clk) begin
        if (!rst_n)         run_q <= '0;
        else if (board_rst) run_q <= run_q + 1'b1;
        else                run_q <= '0;
    end

    // R1: with every mask clear the live configuration is the physical one.
    p_passthru_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (en_flat == '0) |-> (cfg_live == phys_sw));

    // R9: the strobe marks the first cycle of a pulse.
    p_strobe_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_strobe |-> (board_rst && !$past(board_rst)));

    // R9: the strobe lasts one cycle.
    p_strobe_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_strobe |=> !cfg_strobe);

    // R10: the latched word changes only with the strobe.
    p_latch_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_strobe |-> $stable(cfg_latched));

    // R9: every pulse lasts exactly PULSE_LEN cycles.
    p_pulse_len_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(board_rst) |-> (run_q == RUN_W'(PULSE_LEN)));

    // R12: the clock enable moves only after a bus write to its address.
    p_clken_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !($past(bus_wen) && $past(bus_addr) == 8'h04) |-> $stable(freq_apply));

endmodule

bind swcfg_ctrl swcfg_ctrl_chk #(
    .CFG_W     (CFG_W),
    .PULSE_LEN (PULSE_LEN)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_wen     (bus_wen),
    .bus_addr    (bus_addr),
    .phys_sw     (phys_sw),
    .cfg_live    (cfg_live),
    .cfg_latched (cfg_latched),
    .cfg_strobe  (cfg_strobe),
    .board_rst   (board_rst),
    .freq_apply  (freq_apply),
    .en_flat     (en_flat)
);

// File: tb/swcfg_ctrl_tb.sv
`timescale 1ns/1ps
// Self-checking bench for swcfg_ctrl: a table of override patterns walked by
// one loop, then directed tests for the reset triggers and register corners.
module swcfg_ctrl_tb;

    localparam int NBANK = 8;
    localparam int CFG_W = NBANK * 8;
    localparam int PLEN  = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             bus_wen = 1'b0;
    logic [7:0]       bus_addr = '0;
    logic [7:0]       bus_wdata = '0;
    logic [7:0]       bus_rdata;
    logic [CFG_W-1:0] phys_sw = '0;
    logic [CFG_W-1:0] cfg_live;
    logic [CFG_W-1:0] cfg_latched;
    logic             cfg_strobe;
    logic             board_rst;
    logic [23:0]      freq_word;
    logic             freq_apply;

    int n_tests = 0;
    int n_fail  = 0;
    logic [7:0] m_sw [NBANK];
    logic [7:0] m_en [NBANK];

    always #2.5 clk = ~clk;

    swcfg_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wen(bus_wen), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .phys_sw(phys_sw),
        .cfg_live(cfg_live), .cfg_latched(cfg_latched), .cfg_strobe(cfg_strobe),
        .board_rst(board_rst), .freq_word(freq_word), .freq_apply(freq_apply)
    );

    // Vector: bank, physical byte, shadow byte, mask byte, expected live byte.
    typedef struct packed {
        logic [7:0] bank;
        logic [7:0] phys;
        logic [7:0] sw;
        logic [7:0] en;
        logic [7:0] exp;
    } vec_t;
    localparam int NVEC = 6;
    localparam vec_t VECS [NVEC] = '{
        '{8'd0, 8'h0F, 8'hF0, 8'h00, 8'h0F},
        '{8'd1, 8'h0F, 8'hF0, 8'hFF, 8'hF0},
        '{8'd2, 8'h33, 8'hCC, 8'h0F, 8'h3C},
        '{8'd7, 8'hA5, 8'h5A, 8'h81, 8'h24},
        '{8'd3, 8'h00, 8'hFF, 8'h55, 8'h55},
        '{8'd6, 8'hFF, 8'h00, 8'hF0, 8'h0F}
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wen = 1'b1;
        @(negedge clk);
        bus_wen = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    function automatic logic [CFG_W-1:0] model_merge();
        logic [CFG_W-1:0] r;
        for (int b = 0; b < NBANK; b++)
            for (int i = 0; i < 8; i++)
                r[8*b+i] = m_en[b][i] ? m_sw[b][i] : phys_sw[8*b+i];
        return r;
    endfunction

    // Count cycles board_rst stays high from the current negedge.
    task automatic count_high(output int n);
        n = 0;
        while (board_rst && n < 100) begin
            n++;
            @(negedge clk);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #500000;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] rd;
        logic [CFG_W-1:0] snap;
        int n;
        for (int b = 0; b < NBANK; b++) begin m_sw[b] = '0; m_en[b] = '0; end
        phys_sw = 64'h1122_3344_5566_7788;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk("R1 live", cfg_live, phys_sw);
        chk("R1 rst", {board_rst, cfg_strobe, freq_apply}, 3'b000);
        chk("R1 freq", freq_word, 24'h0);
        bus_read(8'h10, rd); chk("R1 sw0", rd, 8'h00);
        bus_read(8'h1F, rd); chk("R1 en7", rd, 8'h00);

        // R2, R3: table of override patterns
        phys_sw = '0;
        for (int v = 0; v < NVEC; v++) begin
            int bk;
            bk = int'(VECS[v].bank);
            phys_sw[8*bk +: 8] = VECS[v].phys;
            bus_write(8'h10 + 8'(2*bk), VECS[v].sw);
            bus_write(8'h11 + 8'(2*bk), VECS[v].en);
            m_sw[bk] = VECS[v].sw;
            m_en[bk] = VECS[v].en;
            chk("R2 merge", cfg_live[8*bk +: 8], VECS[v].exp);
            bus_read(8'h10 + 8'(2*bk), rd); chk("R3 sw readback", rd, VECS[v].sw);
            bus_read(8'h11 + 8'(2*bk), rd); chk("R3 en readback", rd, VECS[v].en);
        end
        chk("R2 full word", cfg_live, model_merge());

        // R4: identity bytes, writes ignored
        bus_write(8'h00, 8'h00);
        bus_write(8'h01, 8'hFF);
        bus_read(8'h00, rd); chk("R4 id", rd, 8'hA7);
        bus_read(8'h01, rd); chk("R4 arch", rd, 8'h12);

        // R5: unmapped addresses
        snap = cfg_live;
        bus_write(8'h08, 8'hFF);
        bus_write(8'h20, 8'hFF);
        bus_read(8'h08, rd); chk("R5 read 08", rd, 8'h00);
        bus_read(8'h20, rd); chk("R5 read 20", rd, 8'h00);
        chk("R5 live unchanged", cfg_live, snap);
        chk("R5 no pulse", {board_rst, freq_apply}, 2'b00);

        // R11, R12: frequency word and enable
        bus_write(8'h05, 8'h12);
        bus_write(8'h06, 8'h34);
        bus_write(8'h07, 8'h56);
        chk("R11 word", freq_word, 24'h123456);
        bus_read(8'h05, rd); chk("R11 msb readback", rd, 8'h12);
        bus_read(8'h07, rd); chk("R11 lsb readback", rd, 8'h56);
        bus_write(8'h04, 8'h01);
        chk("R12 apply on", freq_apply, 1'b1);
        bus_write(8'h04, 8'hFE);
        chk("R12 apply off", freq_apply, 1'b0);
        bus_read(8'h04, rd); chk("R12 readback", rd, 8'h00);

        // R6, R9: plain reset captures physical switches
        phys_sw = 64'hDEAD_BEEF_0123_4567;
        bus_write(8'h02, 8'h5A);
        chk("R6 latched phys", cfg_latched, 64'hDEAD_BEEF_0123_4567);
        chk("R9 strobe first", {board_rst, cfg_strobe}, 2'b11);
        @(negedge clk);
        chk("R9 strobe single", cfg_strobe, 1'b0);
        count_high(n);
        chk("R9 pulse length", n, PLEN - 1);
        bus_read(8'h02, rd); chk("R6 read zero", rd, 8'h00);

        // R7, R10: sequencer reset captures merged; mid-pulse trigger dropped
        phys_sw = 64'h0F0F_F0F0_A5A5_5A5A;
        bus_write(8'h03, 8'h01);
        chk("R7 latched merged", cfg_latched, model_merge());
        chk("R7 pulse", board_rst, 1'b1);
        snap = cfg_latched;
        phys_sw = 64'hFFFF_0000_FFFF_0000;
        bus_write(8'h02, 8'h00);
        chk("R10 latched kept", cfg_latched, snap);
        count_high(n);
        chk("R10 pulse length", n, PLEN - 2);
        bus_read(8'h03, rd); chk("R7 readback", rd, 8'h01);

        // R8: writing 1 again, then 0, starts nothing
        bus_write(8'h03, 8'h01);
        repeat (2) @(negedge clk);
        chk("R8 repeat one", {board_rst, cfg_strobe}, 2'b00);
        bus_write(8'h03, 8'h00);
        repeat (2) @(negedge clk);
        chk("R8 clear", {board_rst, cfg_strobe}, 2'b00);
        chk("R8 latched kept", cfg_latched, snap);

        // R7: a fresh 0->1 fires again with the current merge
        bus_write(8'h03, 8'h01);
        chk("R7 refire", cfg_latched, model_merge());
        count_high(n);
        chk("R9 refire length", n, PLEN);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule